// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog that asks for a system reset only after software has missed two full countdowns in a row. A free-running prescaler divides the clock into a fixed-period tick. The 10-bit counter steps down once per tick while the timer is not halted. Software keeps the timer alive by writing the reload command, which puts the programmed initial value back into the counter.

When the counter is at zero and a tick arrives, that is an expiry. The first expiry sets a sticky first-timeout flag and restarts the countdown. If the flag is still set at the next expiry, the block records a second-timeout flag and a boot flag, and it emits a fixed-length reset request pulse. A no-reboot inhibit bit suppresses the pulse.

Software reaches the registers through a plain word-wide port. Each transfer is one cycle with `req_valid` high. A read returns data one cycle later, flagged by `rd_valid`. The port has no back-pressure: every request is accepted in the cycle it is presented.

Top module: `wdt_twostage`

## Requirements
- R1: The tick fires once every `TICK_DIV` clock cycles. While the timer runs, the counter decreases by one on each tick, and reading offset 0x00 returns the live count in bits [9:0] with zeros above.
- R2: A write of exactly 16'h0001 to offset 0x00 loads the counter from the initial value in the next cycle. A write of any other value there changes nothing.
- R3: The initial value sits in bits [9:0] at offset 0x12 and resets to `RESET_INIT`. Bits [15:10] of that offset are reserved: writes do not change them and they read 0.
- R4: A write to offset 0x12 whose bits [9:0] are below 4 is dropped, and the previous initial value stays.
- R5: Offset 0x08 is the control register. Bit 11 is the halt bit and bit 0 is the no-reboot bit. After reset, bit 11 is 1 and bit 0 is 0. While bit 11 is 1 the counter holds its value.
- R6: The first expiry (a tick with the counter at 0 and the timer running) sets bit 3 of offset 0x04 and reloads the counter from the initial value.
- R7: An expiry while bit 3 of 0x04 is set reloads the counter and sets bit 1 of offset 0x06. If that bit was clear and no-reboot is 0, the expiry also sets bit 2 of 0x06 (boot) and drives `sys_rst_req` high for `PULSE_LEN` cycles, starting the cycle after the expiry. No new pulse starts while bit 1 of 0x06 stays set.
- R8: With no-reboot set, a second expiry still sets bit 1 of 0x06 but raises neither `sys_rst_req` nor the boot bit.
- R9: Status bits are write-1-to-clear, and a set in the same cycle wins over a clear. Clearing bit 3 of 0x04 before the second expiry means two more full countdowns are needed before a reset.
- R10: A reload command in the same cycle as an expiry takes precedence: the counter reloads, and no status bit changes and no pulse starts.
- R11: A read request produces `rd_valid` exactly one cycle later. Offsets other than 0x00, 0x04, 0x06, 0x08 and 0x12 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register transfer present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register byte offset |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read request) |
| rd_data | output | 16 | Read data |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The assertions assume a few things about the block's inputs and settings:
- `rst_n` is low at start-up.
- `req_addr` and `req_wdata` are known whenever `req_valid` is high.
- `RESET_INIT` is at least 4 and `PULSE_LEN` is at least 1.
- `TICK_DIV` is above 1 wherever tick spacing is checked.

The stimulus stays within these limits. It drives every request at the falling edge and holds it for exactly one clock. It keeps the parameters in range. Random writes to the initial value deliberately include values 0 to 3, so the rejection path is exercised.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int CNT_W    = 10;
  localparam int MIN_INIT = 4;

  localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT1  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT2  = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_INIT   = 5'h12;

  localparam int BIT_TMO1     = 3;
  localparam int BIT_TMO2     = 1;
  localparam int BIT_BOOT     = 2;
  localparam int BIT_HALT     = 11;
  localparam int BIT_NOREBOOT = 0;

  localparam logic [DATA_W-1:0] RELOAD_CMD = 16'h0001;

  typedef struct packed {
    logic tmo1;
    logic tmo2;
    logic boot;
  } wdt_status_t;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);

      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R1
    end
  endgenerate
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int CW = 10,
  parameter int RESET_INIT = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          reload_i,
  input  logic [CW-1:0] init_i,
  output logic [CW-1:0] count_o,
  output logic          expire_o
);
  logic [CW-1:0] count_q;
  logic          at_zero;

  assign at_zero  = (count_q == '0);
  assign expire_o = tick_i && run_i && at_zero && !reload_i;
  assign count_o  = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count_q <= CW'(RESET_INIT);
    else if (reload_i)       count_q <= init_i;
    else if (tick_i && run_i) count_q <= at_zero ? init_i : count_q - 1'b1;
  end

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !reload_i) |=> $stable(count_q)); // R5
  AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (count_q == $past(init_i))); // R2
endmodule

// File: rtl/wdt_reset_pulse.sv
module wdt_reset_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic active_o
);
  localparam int W = $clog2(LEN + 1);
  logic [W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fire_i)         left_q <= W'(LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign active_o = (left_q != '0);

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> active_o); // R7
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
  import wdt_pkg::*;
#(
  parameter int unsigned TICK_DIV = 75000000,
  parameter int RESET_INIT = 50,
  parameter int PULSE_LEN  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sys_rst_req
);
  logic              tick;
  logic              wr_c, rd_c, reload_c, expire_c, second_c, fire_c;
  logic              halt_q, noreboot_q;
  logic [CNT_W-1:0]  init_q, count;
  wdt_status_t       st_q;
  logic              clr1_c, clr2_c, clrb_c;
  logic [DATA_W-1:0] rd_next;

  assign wr_c     = req_valid && req_write;
  assign rd_c     = req_valid && !req_write;
  assign reload_c = wr_c && (req_addr == OFS_RELOAD) && (req_wdata == RELOAD_CMD);

  wdt_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick));

  wdt_down_counter #(.CW(CNT_W), .RESET_INIT(RESET_INIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(!halt_q),
    .reload_i(reload_c), .init_i(init_q), .count_o(count), .expire_o(expire_c));

  assign second_c = expire_c && st_q.tmo1;
  assign fire_c   = second_c && !st_q.tmo2 && !noreboot_q;

  wdt_reset_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire_i(fire_c), .active_o(sys_rst_req));

  // control and initial value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q     <= 1'b1;
      noreboot_q <= 1'b0;
      init_q     <= CNT_W'(RESET_INIT);
    end else if (wr_c) begin
      if (req_addr == OFS_CTRL) begin
        halt_q     <= req_wdata[BIT_HALT];
        noreboot_q <= req_wdata[BIT_NOREBOOT];
      end
      if ((req_addr == OFS_INIT) && (req_wdata[CNT_W-1:0] >= CNT_W'(MIN_INIT)))
        init_q <= req_wdata[CNT_W-1:0];
    end
  end

  // sticky status, set wins over clear
  assign clr1_c = wr_c && (req_addr == OFS_STAT1) && req_wdata[BIT_TMO1];
  assign clr2_c = wr_c && (req_addr == OFS_STAT2) && req_wdata[BIT_TMO2];
  assign clrb_c = wr_c && (req_addr == OFS_STAT2) && req_wdata[BIT_BOOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q.tmo1 <= (expire_c && !st_q.tmo1) || (st_q.tmo1 && !clr1_c);
      st_q.tmo2 <= second_c || (st_q.tmo2 && !clr2_c);
      st_q.boot <= fire_c   || (st_q.boot && !clrb_c);
    end
  end

  // read path
  always_comb begin
    rd_next = '0;
    unique case (req_addr)
      OFS_RELOAD: rd_next[CNT_W-1:0]   = count;
      OFS_STAT1:  rd_next[BIT_TMO1]    = st_q.tmo1;
      OFS_STAT2: begin
        rd_next[BIT_TMO2] = st_q.tmo2;
        rd_next[BIT_BOOT] = st_q.boot;
      end
      OFS_CTRL: begin
        rd_next[BIT_HALT]     = halt_q;
        rd_next[BIT_NOREBOOT] = noreboot_q;
      end
      OFS_INIT:   rd_next[CNT_W-1:0]   = init_q;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_c;
      if (rd_c) rd_data <= rd_next;
    end
  end

  AST_FIRST_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_c && !st_q.tmo1) |=> st_q.tmo1); // R6
  AST_RST_NEEDS_T2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> (st_q.tmo2 && st_q.boot)); // R7
  AST_NOREBOOT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> !$past(noreboot_q)); // R8
  AST_INIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    init_q >= CNT_W'(MIN_INIT)); // R4
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_c |=> rd_valid); // R11
endmodule

// File: tb/tb_wdt_twostage.sv
module tb_wdt_twostage;
  localparam int DIV = 4, RINIT = 6, PLEN = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rd_valid, sys_rst_req;
  logic [15:0] rd_data;

  always #4 clk = ~clk;

  wdt_twostage #(.TICK_DIV(DIV), .RESET_INIT(RINIT), .PULSE_LEN(PLEN)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .sys_rst_req(sys_rst_req));

  int checks = 0, errors = 0, cyc = 0, rst_hi = 0;
  bit done = 0;

  // reference model state
  int         m_pre, m_pc;
  logic [9:0] m_cnt, m_init;
  logic       m_halt, m_nr, m_t1, m_t2, m_boot, m_rdv;
  logic [15:0] m_rd;
  logic [4:0]  m_rd_addr;

  function automatic logic [15:0] model_read(input logic [4:0] a);
    case (a)
      5'h00: return {6'b0, m_cnt};
      5'h04: return {12'b0, m_t1, 3'b0};
      5'h06: return {13'b0, m_boot, m_t2, 1'b0};
      5'h08: return {4'b0, m_halt, 10'b0, m_nr};
      5'h12: return {6'b0, m_init};
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'h00: return "R1";
      5'h04: return "R6";
      5'h06: return "R7";
      5'h08: return "R5";
      5'h12: return "R3";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic tick, wr, rel, expv, sec, fire;
    if (!rst_n) begin
      m_pre = 0; m_pc = 0; m_cnt = RINIT; m_init = RINIT;
      m_halt = 1; m_nr = 0; m_t1 = 0; m_t2 = 0; m_boot = 0; m_rdv = 0; m_rd = 0;
    end else begin
      tick = (m_pre == DIV - 1);
      wr   = req_valid && req_write;
      rel  = wr && req_addr == 5'h00 && req_wdata == 16'h0001;
      expv = tick && !m_halt && m_cnt == 0 && !rel;
      sec  = expv && m_t1;
      fire = sec && !m_t2 && !m_nr;
      m_rdv = req_valid && !req_write;
      if (m_rdv) begin m_rd = model_read(req_addr); m_rd_addr = req_addr; end
      if (rel) m_cnt = m_init;
      else if (tick && !m_halt) m_cnt = (m_cnt == 0) ? m_init : m_cnt - 10'd1;
      m_t1   = (expv && !m_t1) || (m_t1 && !(wr && req_addr == 5'h04 && req_wdata[3]));
      m_t2   = sec  || (m_t2   && !(wr && req_addr == 5'h06 && req_wdata[1]));
      m_boot = fire || (m_boot && !(wr && req_addr == 5'h06 && req_wdata[2]));
      if (fire) m_pc = PLEN; else if (m_pc != 0) m_pc = m_pc - 1;
      if (wr && req_addr == 5'h08) begin m_halt = req_wdata[11]; m_nr = req_wdata[0]; end
      if (wr && req_addr == 5'h12 && req_wdata[9:0] >= 10'd4) m_init = req_wdata[9:0];
      m_pre = tick ? 0 : m_pre + 1;
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({15'b0, sys_rst_req}, {15'b0, m_pc != 0}, "R7");
      chk({15'b0, rd_valid}, {15'b0, m_rdv}, "R11");
      if (m_rdv) chk(rd_data, m_rd, tag_of(m_rd_addr));
      if (sys_rst_req) rst_hi++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic xfer(input logic w, input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : stim
    int base;
    void'($urandom(32'd20240611));
    idle(5);
    rst_n = 1;
    // reset state
    xfer(0, 5'h08, 0); chk(rd_data, 16'h0800, "R5");
    xfer(0, 5'h12, 0); chk(rd_data, 16'(RINIT), "R3");
    xfer(0, 5'h00, 0); chk(rd_data, 16'(RINIT), "R1");
    xfer(0, 5'h04, 0); chk(rd_data, 16'h0, "R6");
    xfer(0, 5'h06, 0); chk(rd_data, 16'h0, "R7");
    xfer(0, 5'h0A, 0); chk(rd_data, 16'h0, "R11");
    // rejected initial values
    xfer(1, 5'h12, 16'hFC02); xfer(0, 5'h12, 0); chk(rd_data, 16'(RINIT), "R4");
    xfer(1, 5'h12, 16'hFC03); xfer(0, 5'h12, 0); chk(rd_data, 16'(RINIT), "R4");
    xfer(1, 5'h12, 16'hFC05); xfer(0, 5'h12, 0); chk(rd_data, 16'h0005, "R3");
    // reload while halted
    xfer(1, 5'h00, 16'h0001); xfer(0, 5'h00, 0); chk(rd_data, 16'h0005, "R2");
    idle(20); xfer(0, 5'h00, 0); chk(rd_data, 16'h0005, "R5");
    // unserviced: two expiries -> reset
    base = rst_hi;
    xfer(1, 5'h08, 16'h0000);
    idle(100);
    xfer(0, 5'h06, 0); chk(rd_data, 16'h0006, "R7");
    chk(16'(rst_hi - base), 16'(PLEN), "R7");
    // no re-issue while second-timeout stays set
    base = rst_hi; idle(100);
    chk(16'(rst_hi - base), 16'h0, "R7");
    // clear everything, inhibit reboot
    xfer(1, 5'h06, 16'h0006); xfer(1, 5'h04, 16'h0008);
    xfer(0, 5'h06, 0); chk(rd_data, 16'h0, "R9");
    base = rst_hi;
    xfer(1, 5'h08, 16'h0001);
    idle(100);
    xfer(0, 5'h06, 0); chk(rd_data, 16'h0002, "R8");
    chk(16'(rst_hi - base), 16'h0, "R8");
    // regular service of first-timeout keeps reset away
    xfer(1, 5'h06, 16'h0006); xfer(1, 5'h08, 16'h0000);
    base = rst_hi;
    for (int i = 0; i < 20; i++) begin idle(13); xfer(1, 5'h04, 16'h0008); end
    xfer(0, 5'h06, 0); chk(rd_data, 16'h0, "R9");
    chk(16'(rst_hi - base), 16'h0, "R9");
    // reload in the same cycle as an expiry
    xfer(1, 5'h04, 16'h0008);
    @(negedge clk);
    while (!(m_cnt == 0 && m_pre == DIV - 1 && !m_t1)) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 5'h00; req_wdata = 16'h0001;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    xfer(0, 5'h04, 0); chk(rd_data, 16'h0, "R10");
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int unsigned sel = $urandom_range(0, 9);
      logic [15:0] d = 16'($urandom);
      case (sel)
        0, 1: xfer(1, 5'h00, ($urandom_range(0, 9) < 7) ? 16'h0001 : d);
        2:    xfer(1, 5'h04, ($urandom_range(0, 3) == 0) ? 16'h0008 : 16'h0);
        3:    xfer(1, 5'h06, {13'b0, d[2:1], 1'b0} & {16{$urandom_range(0, 3) == 0}});
        4:    xfer(1, 5'h08, {4'b0, $urandom_range(0, 7) == 0, 10'b0, d[0]});
        5:    xfer(1, 5'h12, {d[15:10], 10'($urandom_range(0, 12))});
        default: xfer(0, 5'($urandom_range(0, 19)), 0);
      endcase
      idle($urandom_range(0, 6));
    end
    idle(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule